// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns a 32-bit product. The sign is the XOR of the operand signs. The exponent is the sum of the biased exponents minus 127. The two 24-bit significands, with their implicit leading one restored, form a 48-bit product. That product is normalized and then rounded to nearest, ties to even. If rounding carries out, the result is normalized a second time.

NaN, infinity and zero operands do not use the product. A bypass path chooses the result word for them. Inputs with a zero exponent field are treated as zero. Results below the normal range become zero, and results above it become infinity.

Both sides of the block use a valid/ready stream with one global stall. An operand pair is taken on any clock edge where `in_valid` and `in_ready` are both high. A result is handed over on any edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every stage holds and `in_ready` is low. The parameter `MID_REG` adds a register between the multiply and the round/pack logic, which raises the latency from 1 to 2 cycles.

Top module: `fp32_mul`

## Requirements
- R1: For two finite nonzero operands, result bit 31 is the XOR of bit 31 of each operand.
- R2: For normal operands, the exponent is ea+eb-127, taken from the exponent fields in bits 30:23, and the significand is the 48-bit product of {1,frac}. A product of 2 or more shifts right by one and raises the exponent by one. Exact products are returned unchanged.
- R3: Rounding keeps 24 bits and adds one ulp only when round bit AND (kept LSB OR sticky) is true. The round bit is the first dropped bit, and sticky is the OR of all lower dropped bits.
- R4: A rounding carry out of the 24-bit significand gives a fraction of zero and raises the exponent by one.
- R5: A final biased exponent of 255 or more, counted after both normalizations, gives infinity with the product sign (exponent field all ones, fraction zero).
- R6: A final biased exponent of 0 or less gives zero with the product sign. Any operand whose exponent field is zero is treated as a zero of its own sign, so no subnormal word is ever output.
- R7: A NaN on either operand, or zero times infinity, gives exactly 0x7FC00000. A NaN operand is an exponent field of all ones with a nonzero fraction.
- R8: Infinity times a nonzero operand gives infinity with the XOR sign. Zero times a finite operand gives zero with the XOR sign.
- R9: With `out_ready` high, a pair accepted on one edge appears on `out_valid`/`out_data` 1+MID_REG edges later. `in_ready` is high whenever `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and no new operand is accepted.
- R11: During and right after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Product word |

## Verification
Two pairs of functions can act in the same cycle. The first pair is rounding carry and overflow. An operand of fraction 0x7FFFFE at exponent 254, multiplied by 1+2^-23, only crosses into the overflow range through the rounding carry, so the expected result is infinity rather than the largest finite value. The second pair is rounding carry and underflow. A product whose exponent before rounding is 0 is carried back to the smallest normal word 0x00800000 instead of being flushed to zero. The stall is tested by holding `out_ready` low over a finished result while a second pair is offered. The held word must not change, and the second pair must come out only after the stall ends.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXP_IW = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_NORM = 2'd1,
    CL_INF  = 2'd2,
    CL_NAN  = 2'd3
  } fp_class_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    fp_class_e        cls;
  } fp_op_t;

  typedef struct packed {
    logic                     sign;
    logic signed [EXP_IW-1:0] exp;
    logic [PROD_W-1:0]        prod;
    logic                     bypass;
    logic [WORD_W-1:0]        byp_word;
  } fp_mid_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fp_op_t            op
);
  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] f_fld;

  assign e_fld = word[WORD_W-2 -: EXP_W];
  assign f_fld = word[FRAC_W-1:0];

  always_comb begin
    op.sign = word[WORD_W-1];
    op.exp  = e_fld;
    op.sig  = {1'b1, f_fld};
    if (e_fld == '0)
      op.cls = CL_ZERO;            // subnormals flushed here
    else if (e_fld == {EXP_W{1'b1}})
      op.cls = (f_fld == '0) ? CL_INF : CL_NAN;
    else
      op.cls = CL_NORM;
  end
endmodule

// File: rtl/fpm_core.sv
module fpm_core
  import fpm_pkg::*;
(
  input  fp_op_t  a,
  input  fp_op_t  b,
  output fp_mid_t m
);
  logic psign, any_nan, any_inf, any_zero;

  assign psign    = a.sign ^ b.sign;
  assign any_nan  = (a.cls == CL_NAN)  || (b.cls == CL_NAN);
  assign any_inf  = (a.cls == CL_INF)  || (b.cls == CL_INF);
  assign any_zero = (a.cls == CL_ZERO) || (b.cls == CL_ZERO);

  always_comb begin
    m.sign = psign;
    m.exp  = $signed({2'b00, a.exp}) + $signed({2'b00, b.exp})
             - $signed(EXP_IW'(BIAS));
    m.prod = PROD_W'(a.sig) * PROD_W'(b.sig);
    m.bypass   = any_nan || any_inf || any_zero;
    if (any_nan || (any_inf && any_zero))
      m.byp_word = CANON_NAN;
    else if (any_inf)
      m.byp_word = {psign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      m.byp_word = {psign, {(WORD_W-1){1'b0}}};
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  fp_mid_t           m,
  output logic [WORD_W-1:0] word
);
  localparam logic signed [EXP_IW-1:0] EXP_TOP = EXP_IW'(EXP_ALL1);

  logic                     hi, rbit, sticky, inc, carry;
  logic [SIG_W-1:0]         kept;
  logic [SIG_W:0]           rnd;
  logic signed [EXP_IW-1:0] e_fin;

  assign hi = m.prod[PROD_W-1];

  always_comb begin
    if (hi) begin
      kept   = m.prod[PROD_W-1 -: SIG_W];
      rbit   = m.prod[PROD_W-SIG_W-1];
      sticky = |m.prod[PROD_W-SIG_W-2:0];
    end else begin
      kept   = m.prod[PROD_W-2 -: SIG_W];
      rbit   = m.prod[PROD_W-SIG_W-2];
      sticky = |m.prod[PROD_W-SIG_W-3:0];
    end
  end

  assign inc   = rbit & (kept[0] | sticky);
  assign rnd   = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
  assign carry = rnd[SIG_W];
  assign e_fin = m.exp + $signed({{(EXP_IW-1){1'b0}}, hi})
                       + $signed({{(EXP_IW-1){1'b0}}, carry});

  always_comb begin
    if (m.bypass)
      word = m.byp_word;
    else if (e_fin >= EXP_TOP)
      word = {m.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_fin <= 0)
      word = {m.sign, {(WORD_W-1){1'b0}}};
    else
      word = {m.sign, e_fin[EXP_W-1:0],
              carry ? {FRAC_W{1'b0}} : rnd[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
  import fpm_pkg::*;
#(
  parameter bit MID_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  fp_op_t            op_a, op_b;
  fp_mid_t           mid_d, mid_s;
  logic              v_s, advance;
  logic [WORD_W-1:0] res_w;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  fpm_unpack u_unp_a (.word(in_a), .op(op_a));
  fpm_unpack u_unp_b (.word(in_b), .op(op_b));
  fpm_core   u_core  (.a(op_a), .b(op_b), .m(mid_d));

  generate
    if (MID_REG) begin : g_mid
      fp_mid_t mid_q;
      logic    v_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       v_q <= 1'b0;
        else if (advance) v_q <= in_valid;
      end
      always_ff @(posedge clk) begin
        if (advance) mid_q <= mid_d;
      end
      assign mid_s = mid_q;
      assign v_s   = v_q;
    end else begin : g_flow
      assign mid_s = mid_d;
      assign v_s   = in_valid;
    end
  endgenerate

  fpm_round u_round (.m(mid_s), .word(res_w));

  always_ff @(posedge clk) begin
    if (!rst_n)       out_valid <= 1'b0;
    else if (advance) out_valid <= v_s;
  end

  always_ff @(posedge clk) begin
    if (advance) out_data <= res_w;
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk #(
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, LAT));

  // R7
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[30:23] == 8'hFF && out_data[22:0] != 23'd0
      |-> out_data == 32'h7FC00000);

  // R6
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[30:23] == 8'h00 |-> out_data[22:0] == 23'd0);
endmodule

bind fp32_mul fp32_mul_chk #(.LAT(1 + int'(MID_REG))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fp32_mul_test.sv
module fp32_mul_test;
  localparam bit MID = 1'b1;
  localparam int LAT = 1 + int'(MID);
  localparam int NV  = 24;

  // {a, b, expected}
  localparam logic [95:0] VEC [NV] = '{
    {32'h41CC0000, 32'hBEC00000, 32'hC1190000}, // 0  R1 R2
    {32'h40066666, 32'h40066666, 32'h408D1EB7}, // 1  R2
    {32'h3F800000, 32'h3F800000, 32'h3F800000}, // 2  R2
    {32'h40000000, 32'h40400000, 32'h40C00000}, // 3  R2
    {32'hBFC00000, 32'hBFC00000, 32'h40100000}, // 4  R1
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002}, // 5  R3 tie, odd -> up
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004}, // 6  R3 tie, even -> stay
    {32'h3F800001, 32'h3F800001, 32'h3F800002}, // 7  R3 below half
    {32'h3FFFFFFE, 32'h3F800001, 32'h40000000}, // 8  R4 carry
    {32'h7F000000, 32'h40000000, 32'h7F800000}, // 9  R5
    {32'hFF000000, 32'h40000000, 32'hFF800000}, // 10 R5
    {32'h7F7FFFFE, 32'h3F800001, 32'h7F800000}, // 11 R5 via carry
    {32'h00800000, 32'h3F000000, 32'h00000000}, // 12 R6
    {32'h80800000, 32'h3F000000, 32'h80000000}, // 13 R6
    {32'h00000001, 32'h3F800000, 32'h00000000}, // 14 R6 flush input
    {32'h80400000, 32'h3F800000, 32'h80000000}, // 15 R6 flush input
    {32'h00FFFFFE, 32'h3F000001, 32'h00800000}, // 16 R6 rescued by carry
    {32'h7FC00001, 32'h3F800000, 32'h7FC00000}, // 17 R7
    {32'h00000000, 32'h7F800000, 32'h7FC00000}, // 18 R7
    {32'hFF800000, 32'h80000000, 32'h7FC00000}, // 19 R7
    {32'h7F800000, 32'hC0000000, 32'hFF800000}, // 20 R8
    {32'h80000000, 32'h40A00000, 32'h80000000}, // 21 R8
    {32'hFF800000, 32'hFF800000, 32'h7F800000}, // 22 R8
    {32'h3F800000, 32'hFF800001, 32'h7FC00000}  // 23 R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp32_mul #(.MID_REG(MID)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic string req_of(int i);
    if (i <= 4)  return "R1/R2";
    if (i <= 7)  return "R3";
    if (i == 8)  return "R4";
    if (i <= 11) return "R5";
    if (i <= 16) return "R6";
    if (i <= 19 || i == 23) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(int i);
    int n;
    @(negedge clk);
    in_a = VEC[i][95:64];
    in_b = VEC[i][63:32];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (!out_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(req_of(i), out_data, VEC[i][31:0]);
    if (i == 0) check("R9 latency", 32'(n), 32'(LAT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: stall holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 32'h40000000; in_b = 32'h40400000; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h3FC00000; in_b = 32'h40000000;
    repeat (LAT + 2) @(negedge clk);
    check("R10 held valid", {31'd0, out_valid}, 32'd1);
    check("R10 held data", out_data, 32'h40C00000);
    check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 data stable", out_data, 32'h40C00000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(negedge clk);
    check("R10 next result", out_data, 32'h40400000);
    check("R9 ready when idle", {31'd0, in_ready}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule